// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device-side bookkeeping for one receive queue whose descriptors live in a circular ring in host memory. Each descriptor names exactly one receive buffer. Host software programs the ring geometry and a base address, then hands descriptors to the device by moving a write index forward. The receive datapath asks for the next free slot, consumes it, and the controller records which slot was filled. It then emits a status word for the host that carries that slot number, and raises an interrupt either at once or after a coalescing delay.

The fill interface is a valid/ready stream. `fill_ready` depends only on stored state, never on `fill_valid`. A slot is consumed on a cycle where both are high. While `fill_ready` is low the datapath may hold `fill_valid` high, and nothing changes until room appears. `fill_slot` names the descriptor that the next handshake will consume. Register writes, `tick` and the outputs `status_wr` and `host_irq` are plain single-cycle signals.

Register map (2-bit select). Select 0 is the configuration word: bits 3:0 hold log2 of the ring size, bits 11:4 hold the timeout, and bit 12 is the interrupt enable. Select 1 is the ring base: bits 27:0 are address bits 35:8, so the ring is 256-byte aligned. Select 2 is the host write index, in bits 11:0.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset, the outputs hold these values: `fill_slot` = 0, `fill_ready` = 0 (no descriptors available), `status_word` = 0, `status_wr` = 0, `host_irq` = 0 and `ring_base` = 0. The configuration resets to a ring of 256 entries, a timeout of 0 and interrupts disabled.
- R2: A write to select 2 sets the host write index to `wdata[11:0]` with bits 2:0 forced to zero. Writing 13 therefore makes exactly 8 descriptors available from slot 0.
- R3: `fill_ready` is low exactly when `fill_slot` equals the host write index. While it is low, no slot is consumed.
- R4: Each handshake advances `fill_slot` by one, modulo the ring size, so the slot after the last entry is 0.
- R5: On the clock edge of a handshake, `status_wr` rises for one cycle and `status_word` becomes the consumed slot in bits 11:0, with bits 31:12 zero.
- R6: A write to select 1 loads `ring_base` with `wdata[27:0]`. Bits 31:28 are ignored.
- R7: Config bits 3:0 give log2 of the ring size, clamped to the range 4 to 12 (16 to 4096 entries). A host write index is reduced modulo the ring size.
- R8: With the interrupt enabled and the timeout at 0, `host_irq` pulses on the same edge as `status_wr`, once for every fill.
- R9: With the interrupt enabled and a timeout T that is not zero, the first fill that is not yet reported loads a counter with T. Later fills do not reload it. Each `tick` decrements the counter, and `host_irq` pulses for one cycle on the edge of the T-th tick. No interrupt is raised on any cycle without a tick.
- R10: With the interrupt disabled, `host_irq` stays low and any pending unreported fills are dropped.
- R11: `fill_valid` while `fill_ready` is low has no effect: `fill_slot` holds and `status_wr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 config, 1 base, 2 write index) |
| reg_wdata | input | 32 | Register write data |
| fill_valid | input | 1 | Datapath requests a slot |
| fill_ready | output | 1 | A free descriptor is available |
| fill_slot | output | 12 | Slot the next handshake consumes |
| tick | input | 1 | Timeout time base pulse |
| ring_base | output | 28 | Ring base address bits 35:8 |
| status_wr | output | 1 | Status word update strobe |
| status_word | output | 32 | Last filled slot in bits 11:0 |
| host_irq | output | 1 | Host interrupt pulse |

## Verification
The bench targets the ring-full point: it hands over a misaligned write index and expects exactly eight fills before back-pressure. A design that kept the low bits, or that compared indices off by one, would accept a different number of fills or overrun the host. It also shrinks the ring below the minimum size and drives the slot across the wrap, which catches a missing size clamp or a bad modulo, since either one makes the slot sequence diverge. Finally it counts interrupt pulses in the immediate, coalesced and disabled modes. A timer that reloads on every fill, fires a tick too early, or ignores the enable shows up as a pulse in the wrong cycle or a wrong pulse count.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int IDX_W     = 12;
  localparam int LOG2_W    = 4;
  localparam int MIN_LOG2  = 4;
  localparam int MAX_LOG2  = 12;
  localparam int DEF_LOG2  = 8;
  localparam int STEP_LOG2 = 3;
  localparam int TMO_W     = 8;
  localparam int BASE_W    = 28;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_WIDX = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic             irq_en;
    logic [TMO_W-1:0] tmo;
    logic [IDX_W-1:0] mask;
  } ring_cfg_t;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int P_IDX_W  = IDX_W,
  parameter int P_TMO_W  = TMO_W,
  parameter int P_BASE_W = BASE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          sel,
  input  logic [DATA_W-1:0]   wdata,
  output ring_cfg_t           cfg,
  output logic [P_BASE_W-1:0] base,
  output logic [P_IDX_W-1:0]  widx
);
  localparam int TMO_LSB = LOG2_W;
  localparam int EN_BIT  = LOG2_W + P_TMO_W;

  logic [LOG2_W-1:0]  size_lg;
  logic [LOG2_W-1:0]  eff_lg;
  logic [P_TMO_W-1:0] tmo_q;
  logic               en_q;
  logic [P_IDX_W-1:0] mask;
  logic [P_IDX_W-1:0] step_mask;

  always_comb begin
    if (size_lg < LOG2_W'(MIN_LOG2))      eff_lg = LOG2_W'(MIN_LOG2);
    else if (size_lg > LOG2_W'(MAX_LOG2)) eff_lg = LOG2_W'(MAX_LOG2);
    else                                  eff_lg = size_lg;
  end

  assign mask      = P_IDX_W'((32'd1 << eff_lg) - 32'd1);
  assign step_mask = ~P_IDX_W'((32'd1 << STEP_LOG2) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_lg <= LOG2_W'(DEF_LOG2);
      tmo_q   <= '0;
      en_q    <= 1'b0;
      base    <= '0;
      widx    <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(sel))
        SEL_CFG: begin
          size_lg <= wdata[LOG2_W-1:0];
          tmo_q   <= wdata[TMO_LSB +: P_TMO_W];
          en_q    <= wdata[EN_BIT];
        end
        SEL_BASE: base <= wdata[P_BASE_W-1:0];
        SEL_WIDX: widx <= wdata[P_IDX_W-1:0] & mask & step_mask;
        default: ;
      endcase
    end
  end

  assign cfg.irq_en = en_q;
  assign cfg.tmo    = tmo_q;
  assign cfg.mask   = mask;

  assert_widx_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    widx[STEP_LOG2-1:0] == '0);

  assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_BASE) |=> base == $past(wdata[P_BASE_W-1:0]));

  assert_size_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask[MIN_LOG2-1:0] == '1);
endmodule

// File: rtl/rx_ring_fill.sv
module rx_ring_fill
  import rx_ring_pkg::*;
#(
  parameter int P_IDX_W = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_IDX_W-1:0] mask,
  input  logic [P_IDX_W-1:0] widx,
  input  logic               fill_valid,
  output logic               fill_ready,
  output logic [P_IDX_W-1:0] slot,
  output logic               fire,
  output logic               status_wr,
  output logic [DATA_W-1:0]  status_word
);
  localparam int PAD_W = DATA_W - P_IDX_W;

  assign fill_ready = (slot != widx);
  assign fire       = fill_valid && fill_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot        <= '0;
      status_wr   <= 1'b0;
      status_word <= '0;
    end else begin
      status_wr <= fire;
      if (fire) begin
        slot        <= (slot + P_IDX_W'(1)) & mask;
        status_word <= {{PAD_W{1'b0}}, slot};
      end
    end
  end

  assert_hold_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ready |=> slot == $past(slot));

  assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> slot == (($past(slot) + P_IDX_W'(1)) & $past(mask)));

  assert_status_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status_wr && status_word[P_IDX_W-1:0] == $past(slot));

  assert_status_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[DATA_W-1:P_IDX_W] == '0);

  assert_no_status_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_ready) |=> !status_wr);
endmodule

// File: rtl/rx_ring_irq.sv
module rx_ring_irq
  import rx_ring_pkg::*;
#(
  parameter int P_TMO_W = TMO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_en,
  input  logic [P_TMO_W-1:0] tmo,
  input  logic               fire,
  input  logic               tick,
  output logic               host_irq
);
  logic               pending;
  logic [P_TMO_W-1:0] timer;
  logic               expire;

  assign expire = pending && tick && (timer == P_TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      timer    <= '0;
      host_irq <= 1'b0;
    end else begin
      host_irq <= 1'b0;
      if (!irq_en) begin
        pending <= 1'b0;
      end else if (tmo == '0) begin
        pending  <= 1'b0;
        host_irq <= fire;
      end else if (expire) begin
        host_irq <= 1'b1;
        if (fire) timer <= tmo;
        else      pending <= 1'b0;
      end else if (pending && tick) begin
        timer <= timer - P_TMO_W'(1);
      end else if (!pending && fire) begin
        pending <= 1'b1;
        timer   <= tmo;
      end
    end
  end

  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !host_irq);

  assert_immediate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && tmo == '0 && fire) |=> host_irq);

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && tmo != '0 && !tick) |=> !host_irq);
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              fill_valid,
  output logic              fill_ready,
  output logic [11:0]       fill_slot,
  input  logic              tick,
  output logic [27:0]       ring_base,
  output logic              status_wr,
  output logic [31:0]       status_word,
  output logic              host_irq
);
  ring_cfg_t        cfg;
  logic [IDX_W-1:0] widx;
  logic             fire;

  rx_ring_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .cfg   (cfg),
    .base  (ring_base),
    .widx  (widx)
  );

  rx_ring_fill u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask        (cfg.mask),
    .widx        (widx),
    .fill_valid  (fill_valid),
    .fill_ready  (fill_ready),
    .slot        (fill_slot),
    .fire        (fire),
    .status_wr   (status_wr),
    .status_word (status_word)
  );

  rx_ring_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_en   (cfg.irq_en),
    .tmo      (cfg.tmo),
    .fire     (fire),
    .tick     (tick),
    .host_irq (host_irq)
  );

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fill_slot == '0 && !host_irq));
endmodule

// File: tb/rx_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_ring_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [11:0] fill_slot;
  logic        tick = 1'b0;
  logic [27:0] ring_base;
  logic        status_wr;
  logic [31:0] status_word;
  logic        host_irq;

  int n_chk = 0;
  int n_bad = 0;
  int n_status = 0;
  int n_irq = 0;
  logic [11:0] exp_q[$];
  logic [11:0] model_slot = '0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_ring_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_slot(fill_slot), .tick(tick), .ring_base(ring_base),
    .status_wr(status_wr), .status_word(status_word), .host_irq(host_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the design publishes a status word
  always @(negedge clk) begin
    if (rst_n) begin
      if (status_wr) begin
        n_status++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected status", status_word, 32'h0);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check(status_word == {20'h0, e}, "R5 status word", status_word, {20'h0, e});
        end
      end
      if (host_irq) n_irq++;
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Driver: one fill attempt; pushes the expected slot when a handshake occurs
  task automatic do_fill(input logic [11:0] mask, output bit took);
    @(negedge clk);
    took = fill_ready;
    if (took) begin
      exp_q.push_back(model_slot);
      check(fill_slot == model_slot, "R4 slot order", {20'h0, fill_slot}, {20'h0, model_slot});
      model_slot = (model_slot + 12'd1) & mask;
    end
    fill_valid = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit took;
    int cnt;
    int st0;
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fill_ready == 1'b0, "R1 ready", {31'h0, fill_ready}, 32'h0);
    check(fill_slot == 12'h0, "R1 slot", {20'h0, fill_slot}, 32'h0);
    check(status_word == 32'h0, "R1 status", status_word, 32'h0);
    check(host_irq == 1'b0 && status_wr == 1'b0, "R1 strobes", {30'h0, host_irq, status_wr}, 32'h0);
    check(ring_base == 28'h0, "R1 base", {4'h0, ring_base}, 32'h0);

    // R6 base load, top bits dropped
    wr_reg(2'd1, 32'hFABC_DEF1);
    check(ring_base == 28'hABC_DEF1, "R6 base", {4'h0, ring_base}, 32'h0ABC_DEF1);

    // R11 valid held while empty has no effect
    st0 = n_status;
    @(negedge clk); fill_valid = 1'b1;
    repeat (4) @(negedge clk);
    fill_valid = 1'b0;
    @(negedge clk);
    check(n_status == st0, "R11 no status", n_status, st0);
    check(fill_slot == 12'h0, "R11 slot held", {20'h0, fill_slot}, 32'h0);

    // R2/R3: write index 13 opens exactly 8 descriptors (default ring 256)
    wr_reg(2'd2, 32'd13);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      do_fill(12'hFF, took);
      if (took) cnt++;
    end
    check(cnt == 8, "R2 fills allowed", cnt, 8);
    check(fill_ready == 1'b0, "R3 full at write index", {31'h0, fill_ready}, 32'h0);
    check(fill_slot == 12'd8, "R3 slot at stop", {20'h0, fill_slot}, 32'd8);

    // R7 lower clamp (log2 2 -> 16 entries), R4 wrap to 0
    wr_reg(2'd0, 32'h0000_0002);
    wr_reg(2'd2, 32'd0);
    for (int i = 0; i < 8; i++) do_fill(12'hF, took);
    check(fill_slot == 12'd0, "R4 wrap to zero", {20'h0, fill_slot}, 32'd0);
    check(fill_ready == 1'b0, "R3 full after wrap", {31'h0, fill_ready}, 32'h0);
    wr_reg(2'd2, 32'h0000_01F8);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      do_fill(12'hF, took);
      if (took) cnt++;
    end
    check(cnt == 8, "R7 index reduced modulo size", cnt, 8);
    check(fill_slot == 12'd8, "R7 slot after modulo", {20'h0, fill_slot}, 32'd8);
    check(n_irq == 0, "R10 no irq while disabled", n_irq, 0);

    // R8 immediate interrupt per fill
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd0, 32'h0000_1002);
    irq0 = n_irq;
    for (int i = 0; i < 2; i++) begin
      do_fill(12'hF, took);
      check(host_irq == 1'b1, "R8 irq with status", {31'h0, host_irq}, 32'h1);
    end
    @(negedge clk);
    check(n_irq == irq0 + 2, "R8 irq count", n_irq, irq0 + 2);

    // R9 coalesced: timeout 3
    wr_reg(2'd0, 32'h0000_1032);
    irq0 = n_irq;
    do_fill(12'hF, took);
    check(host_irq == 1'b0, "R9 no irq on fill", {31'h0, host_irq}, 32'h0);
    repeat (3) @(negedge clk);
    do_fill(12'hF, took);
    pulse_tick();
    pulse_tick();
    check(host_irq == 1'b0, "R9 early", {31'h0, host_irq}, 32'h0);
    pulse_tick();
    check(host_irq == 1'b1, "R9 expiry", {31'h0, host_irq}, 32'h1);
    @(negedge clk);
    check(host_irq == 1'b0, "R9 single pulse", {31'h0, host_irq}, 32'h0);
    for (int i = 0; i < 4; i++) pulse_tick();
    check(n_irq == irq0 + 1, "R9 one irq total", n_irq, irq0 + 1);

    // R10 disabled: pending dropped, no interrupt
    wr_reg(2'd0, 32'h0000_0032);
    irq0 = n_irq;
    do_fill(12'hF, took);
    for (int i = 0; i < 5; i++) pulse_tick();
    check(n_irq == irq0, "R10 silent", n_irq, irq0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all status seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule